// File: doc/BRIEF.md
# Narrow-Link Flit Framer with Serial Lane Acknowledge

This block moves 32-bit flits over a physical channel only nine wires wide, and it sends a per-lane acknowledgment back over a single reverse wire. Every flit period lasts four channel cycles. The sending half cuts the flit into four byte-wide phits. On a ninth side wire it sends the flit's 4-bit lane number, one bit per cycle. The receiving half collects the four phits and the four side bits, then presents the whole flit together with its lane number.

The reverse path works in the opposite direction over the same four-cycle period. The receiving half shifts a 4-bit acknowledgment code out on the one-bit reverse wire. The sending half rebuilds that code. Code 0 means nothing in both fields: an idle flit slot in the forward lane field, and no acknowledgment in the reverse field. Codes 1 to 15 name a lane.

Both halves count the period with their own phase counters. Both counters start together when reset is released, so the link needs no framing marker. Each half accepts new work only in the last cycle of a period and holds its ready signal low in the other cycles. Credit accounting and lane buffering are left to the logic around the block.

Top module: `lane_phit_link`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `fwd_tx` and `rev_tx` are all zeros. `dst_valid`, `ack_seen_valid`, `src_ready` and `ack_ready` are low during the same cycles.
- R2: `src_ready` and `ack_ready` are high together in exactly one cycle of every four. The first such cycle is the fourth cycle after reset is released. A flit or code is taken only at a clock edge where ready is high. Anything offered in other cycles has no effect on the link.
- R3: In cycle k (k = 0..3) of the period that follows acceptance, `fwd_tx[7:0]` carries flit bits [31-8k : 24-8k] and `fwd_tx[8]` carries lane bit 3-k. Both are sent most-significant first.
- R4: When no flit is offered at a period boundary, all nine forward wires are zero for the whole next period. This idle slot has lane code 0.
- R5: `dst_valid` is high for exactly one cycle, the cycle after the fourth phit arrives. `dst_data` and `dst_lane` are valid in that cycle. A period whose lane code is 0 never raises `dst_valid`.
- R6: In cycle k of a period, `rev_tx` carries bit 3-k of the acknowledgment code accepted at the previous boundary. When no code was offered, the wire carries code 0.
- R7: `ack_seen_valid` pulses for one cycle after the fourth reverse bit, with the rebuilt code on `ack_seen_code`. A code of 0 gives no pulse.
- R8: With `fwd_tx` looped to `fwd_rx` and `rev_tx` looped to `rev_rx`, a flit accepted at the edge that ends cycle c appears on `dst_*` in cycle c+5. An acknowledgment code accepted at that same edge appears on `ack_seen_*` in cycle c+5. Order is preserved in both directions.
- R9: Every lane number from 1 to 15 and every 32-bit data value, including all-zeros and all-ones, arrives unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | A flit is offered to the sending half |
| src_ready | output | 1 | Period boundary: the offered flit is taken at this edge |
| src_data | input | 32 | Flit payload |
| src_lane | input | 4 | Lane number of the flit (0 = idle slot) |
| fwd_tx | output | 9 | Outgoing phit: lane bit in [8], data byte in [7:0] |
| rev_rx | input | 1 | Incoming serial acknowledgment bit |
| ack_seen_valid | output | 1 | One-cycle pulse: an acknowledgment code was rebuilt |
| ack_seen_code | output | 4 | Rebuilt acknowledgment code (lane acknowledged) |
| fwd_rx | input | 9 | Incoming phit |
| dst_valid | output | 1 | One-cycle pulse: a flit was rebuilt |
| dst_data | output | 32 | Rebuilt flit payload |
| dst_lane | output | 4 | Rebuilt lane number |
| ack_valid | input | 1 | An acknowledgment code is offered to the receiving half |
| ack_ready | output | 1 | Period boundary: the offered code is taken at this edge |
| ack_code | input | 4 | Acknowledgment code (0 = none, 1..15 = lane) |
| rev_tx | output | 1 | Outgoing serial acknowledgment bit |

## Verification
A phase counter that slipped would first show up at the ready pins, which would leave their one-in-four rhythm within a period. On the loopback it would also garble the rebuilt flit and lane within one period. A fault in a shift register shows up as a wrong bit on `fwd_tx` or `rev_tx` in the very cycle it happens. A lost lane or acknowledgment shows up as a missing or extra pulse on `dst_valid` or `ack_seen_valid` five cycles after the boundary where the flit or code was accepted. The bench compares every output pin against its own model on every clock, so each of these faults shows up in the cycle it reaches the pins.

// File: rtl/lpl_pkg.sv
package lpl_pkg;
  // Cycles per flit period and field widths shared by the framer.
  localparam int unsigned LPL_SLOTS  = 4;
  localparam int unsigned LPL_DATA_W = 32;
  localparam int unsigned LPL_ID_W   = 4;
endpackage

// File: rtl/lpl_phase.sv
module lpl_phase #(
  parameter int unsigned SLOTS = lpl_pkg::LPL_SLOTS
) (
  input  logic clk,
  input  logic rst,
  output logic last
);
  localparam int unsigned CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(SLOTS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (cnt == LAST_V) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  assign last = (cnt == LAST_V);
endmodule

// File: rtl/lpl_ser.sv
module lpl_ser #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SLOTS  = lpl_pkg::LPL_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [WORD_W-1:0]         word,
  output logic [WORD_W/SLOTS-1:0]   slice
);
  localparam int unsigned SW = WORD_W / SLOTS;

  logic [WORD_W-1:0] sh;

  // Load at the boundary, then emit the top slice each cycle, MSB first.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      slice <= '0;
    end else if (load) begin
      slice <= word[WORD_W-1 -: SW];
      sh    <= word << SW;
    end else begin
      slice <= sh[WORD_W-1 -: SW];
      sh    <= sh << SW;
    end
  end
endmodule

// File: rtl/lpl_deser.sv
module lpl_deser #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SLOTS  = lpl_pkg::LPL_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [WORD_W/SLOTS-1:0]   slice_in,
  output logic [WORD_W-1:0]         word_q
);
  localparam int unsigned SW = WORD_W / SLOTS;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] nxt;

  assign nxt = (acc << SW) | WORD_W'(slice_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      word_q <= '0;
    end else begin
      acc <= nxt;
      if (capture) word_q <= nxt;
    end
  end
endmodule

// File: rtl/lane_phit_link.sv
module lane_phit_link #(
  parameter int unsigned SLOTS  = lpl_pkg::LPL_SLOTS,
  parameter int unsigned DATA_W = lpl_pkg::LPL_DATA_W,
  parameter int unsigned ID_W   = lpl_pkg::LPL_ID_W
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   src_valid,
  output logic                                   src_ready,
  input  logic [DATA_W-1:0]                      src_data,
  input  logic [ID_W-1:0]                        src_lane,
  output logic [DATA_W/SLOTS+ID_W/SLOTS-1:0]     fwd_tx,
  input  logic [ID_W/SLOTS-1:0]                  rev_rx,
  output logic                                   ack_seen_valid,
  output logic [ID_W-1:0]                        ack_seen_code,
  input  logic [DATA_W/SLOTS+ID_W/SLOTS-1:0]     fwd_rx,
  output logic                                   dst_valid,
  output logic [DATA_W-1:0]                      dst_data,
  output logic [ID_W-1:0]                        dst_lane,
  input  logic                                   ack_valid,
  output logic                                   ack_ready,
  input  logic [ID_W-1:0]                        ack_code,
  output logic [ID_W/SLOTS-1:0]                  rev_tx
);
  localparam int unsigned DS_W   = DATA_W / SLOTS;
  localparam int unsigned IS_W   = ID_W / SLOTS;
  localparam int unsigned PHIT_W = DS_W + IS_W;

  // ---------------- sending half: flits out, acknowledgments in -------------
  logic              tx_last;
  logic              tx_pulse;
  logic [DATA_W-1:0] tx_data_w;
  logic [ID_W-1:0]   tx_lane_w;
  logic [DS_W-1:0]   tx_data_sl;
  logic [IS_W-1:0]   tx_lane_sl;

  lpl_phase #(.SLOTS(SLOTS)) u_tx_phase (.clk(clk), .rst(rst), .last(tx_last));

  assign src_ready = tx_last;
  assign tx_data_w = src_valid ? src_data : '0;
  assign tx_lane_w = src_valid ? src_lane : '0;

  lpl_ser #(.WORD_W(DATA_W), .SLOTS(SLOTS)) u_ser_data (
    .clk(clk), .rst(rst), .load(tx_last), .word(tx_data_w), .slice(tx_data_sl));
  lpl_ser #(.WORD_W(ID_W), .SLOTS(SLOTS)) u_ser_lane (
    .clk(clk), .rst(rst), .load(tx_last), .word(tx_lane_w), .slice(tx_lane_sl));

  assign fwd_tx = {tx_lane_sl, tx_data_sl};

  lpl_deser #(.WORD_W(ID_W), .SLOTS(SLOTS)) u_deser_ack (
    .clk(clk), .rst(rst), .capture(tx_last), .slice_in(rev_rx), .word_q(ack_seen_code));

  always_ff @(posedge clk) begin
    if (rst) tx_pulse <= 1'b0;
    else     tx_pulse <= tx_last;
  end

  assign ack_seen_valid = tx_pulse & (|ack_seen_code);

  // ---------------- receiving half: flits in, acknowledgments out -----------
  logic            rx_last;
  logic            rx_pulse;
  logic [ID_W-1:0] rx_ack_w;

  lpl_phase #(.SLOTS(SLOTS)) u_rx_phase (.clk(clk), .rst(rst), .last(rx_last));

  lpl_deser #(.WORD_W(DATA_W), .SLOTS(SLOTS)) u_deser_data (
    .clk(clk), .rst(rst), .capture(rx_last), .slice_in(fwd_rx[DS_W-1:0]), .word_q(dst_data));
  lpl_deser #(.WORD_W(ID_W), .SLOTS(SLOTS)) u_deser_lane (
    .clk(clk), .rst(rst), .capture(rx_last), .slice_in(fwd_rx[PHIT_W-1 -: IS_W]), .word_q(dst_lane));

  always_ff @(posedge clk) begin
    if (rst) rx_pulse <= 1'b0;
    else     rx_pulse <= rx_last;
  end

  assign dst_valid = rx_pulse & (|dst_lane);
  assign ack_ready = rx_last;
  assign rx_ack_w  = ack_valid ? ack_code : '0;

  lpl_ser #(.WORD_W(ID_W), .SLOTS(SLOTS)) u_ser_ack (
    .clk(clk), .rst(rst), .load(rx_last), .word(rx_ack_w), .slice(rev_tx));
endmodule

// File: rtl/lpl_checker.sv
module lpl_checker #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned PHIT_W = 9,
  parameter int unsigned REV_W  = 1,
  parameter int unsigned ID_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              src_valid,
  input logic              src_ready,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic [PHIT_W-1:0] fwd_tx,
  input logic [REV_W-1:0]  rev_tx,
  input logic              dst_valid,
  input logic [ID_W-1:0]   dst_lane,
  input logic              ack_seen_valid,
  input logic [ID_W-1:0]   ack_seen_code
);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst)            gap <= 0;
    else if (src_ready) gap <= 0;
    else                gap <= gap + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fwd_tx == '0 && rev_tx == '0 && !dst_valid && !ack_seen_valid));

  assert_ready_cadence_R2: assert property (@(posedge clk) disable iff (rst)
    !src_ready |-> gap < SLOTS - 1);

  assert_ready_single_R2: assert property (@(posedge clk) disable iff (rst)
    src_ready |=> !src_ready);

  assert_halves_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    src_ready == ack_ready);

  assert_idle_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (src_ready && !src_valid) |=> fwd_tx == '0);

  assert_dst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    dst_valid |=> !dst_valid);

  assert_dst_lane_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> dst_lane != '0);

  assert_no_ack_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_ready && !ack_valid) |=> rev_tx == '0);

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ack_seen_valid |=> !ack_seen_valid);

  assert_ack_code_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    ack_seen_valid |-> ack_seen_code != '0);
endmodule

bind lane_phit_link lpl_checker #(
  .SLOTS(SLOTS), .PHIT_W(PHIT_W), .REV_W(IS_W), .ID_W(ID_W)
) i_chk (
  .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
  .ack_valid(ack_valid), .ack_ready(ack_ready), .fwd_tx(fwd_tx), .rev_tx(rev_tx),
  .dst_valid(dst_valid), .dst_lane(dst_lane),
  .ack_seen_valid(ack_seen_valid), .ack_seen_code(ack_seen_code)
);

// File: tb/test_lane_phit_link.sv
module test_lane_phit_link;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] src_data = '0;
  logic [3:0]  src_lane = '0;
  logic [8:0]  fwd_link;
  logic        rev_link;
  logic        ack_seen_valid;
  logic [3:0]  ack_seen_code;
  logic        dst_valid;
  logic [31:0] dst_data;
  logic [3:0]  dst_lane;
  logic        ack_valid = 1'b0;
  logic        ack_ready;
  logic [3:0]  ack_code = '0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  lane_phit_link i_lane_phit_link (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_lane(src_lane),
    .fwd_tx(fwd_link), .rev_rx(rev_link),
    .ack_seen_valid(ack_seen_valid), .ack_seen_code(ack_seen_code),
    .fwd_rx(fwd_link),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_lane(dst_lane),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_code(ack_code),
    .rev_tx(rev_link));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Behavioural model: word currently on the wires and next-cycle expectations.
  logic [31:0] cur_data = '0;
  logic [3:0]  cur_lane = '0;
  logic [3:0]  cur_ack  = '0;
  logic        exp_dv = 1'b0;
  logic [31:0] exp_dd = '0;
  logic [3:0]  exp_dl = '0;
  logic        exp_av = 1'b0;
  logic [3:0]  exp_ac = '0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset is held
    chk(fwd_link === 9'h0, "R1 fwd_tx in reset", 64'(fwd_link), 0);
    chk(rev_link === 1'b0, "R1 rev_tx in reset", 64'(rev_link), 0);
    chk(dst_valid === 1'b0 && ack_seen_valid === 1'b0, "R1 valids in reset",
        64'({dst_valid, ack_seen_valid}), 0);
    chk(src_ready === 1'b0 && ack_ready === 1'b0, "R1 readies in reset",
        64'({src_ready, ack_ready}), 0);
    rst = 1'b0;

    for (int cyc = 0; cyc < 1200; cyc++) begin
      automatic int p = cyc % 4;
      automatic int j = cyc / 4;
      automatic logic [8:0] exp_fwd = {cur_lane[3-p], cur_data[31-8*p -: 8]};

      chk(src_ready === (p == 3), "R2 src_ready cadence", 64'(src_ready), 64'(p == 3));
      chk(ack_ready === (p == 3), "R2 ack_ready cadence", 64'(ack_ready), 64'(p == 3));
      chk(fwd_link === exp_fwd, (cur_lane == 0) ? "R4 idle phit" : "R3 phit format",
          64'(fwd_link), 64'(exp_fwd));
      chk(rev_link === cur_ack[3-p], "R6 reverse bit", 64'(rev_link), 64'(cur_ack[3-p]));
      chk(dst_valid === exp_dv, "R5 dst_valid pulse", 64'(dst_valid), 64'(exp_dv));
      if (exp_dv) begin
        chk(dst_data === exp_dd, "R8 R9 dst_data", 64'(dst_data), 64'(exp_dd));
        chk(dst_lane === exp_dl, "R8 R9 dst_lane", 64'(dst_lane), 64'(exp_dl));
      end
      chk(ack_seen_valid === exp_av, "R7 ack pulse", 64'(ack_seen_valid), 64'(exp_av));
      if (exp_av)
        chk(ack_seen_code === exp_ac, "R7 R8 ack code", 64'(ack_seen_code), 64'(exp_ac));

      if (p == 3) begin
        if (j == 0) begin
          src_valid = 1'b1; src_data = 32'hFFFF_FFFF; src_lane = 4'd15;
          ack_valid = 1'b1; ack_code = 4'd15;
        end else if (j == 1) begin
          src_valid = 1'b1; src_data = 32'h0; src_lane = 4'd1;
          ack_valid = 1'b1; ack_code = 4'd1;
        end else begin
          src_valid = (j % 5 != 2);
          src_data  = 32'(j) * 32'h9E37_79B1 ^ 32'hA5A5_0F0F;
          src_lane  = 4'(j % 16);
          ack_valid = (j % 3 != 1);
          ack_code  = 4'((j * 7) % 16);
        end
        exp_dv = (cur_lane != 0);
        exp_dd = cur_data;
        exp_dl = cur_lane;
        exp_av = (cur_ack != 0);
        exp_ac = cur_ack;
        cur_data = src_valid ? src_data : 32'h0;
        cur_lane = src_valid ? src_lane : 4'h0;
        cur_ack  = ack_valid ? ack_code : 4'h0;
      end else begin
        // R2: offers outside the boundary cycle must not reach the link
        src_valid = 1'b1; src_data = 32'(cyc) * 32'h0101_0101; src_lane = 4'(cyc | 1);
        ack_valid = 1'b1; ack_code = 4'(cyc | 1);
        exp_dv = 1'b0;
        exp_av = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule